// File: doc/BRIEF.md
# Associative Page Translation Unit

This unit translates logical page numbers into physical page numbers for a DRAM memory controller. The table is inverted: there is one slot per physical page, and each slot holds the logical page that is currently mapped onto it. A lookup compares the requested logical page with every valid slot at the same time. The index of the slot that matches becomes the physical page. When no slot matches, the unit raises abort, and the controller must not start a DRAM cycle.

Software fills the table through a programming port. Each write carries a slot index and a logical page number. A select bit decides which controller owns the write. Two controllers can share one table-programming bus: the one that came out of reset as master takes writes with the select low, and the slave takes writes with the select high. The master or slave role is sampled from the byte/word input while reset is held. The physical page output carries the role as its top bit. A single-controller system repeats its physical image every 128 pages, and a dual system spans 256 pages.

Top module: `page_xlate_cam`

## Requirements
- R1: While reset is held and after it is released, every slot is invalid. Any lookup made before the first accepted write therefore aborts.
- R2: An accepted write to slot i with logical page L makes a later lookup of L hit. The low 7 bits of `xl_ppn` then equal i.
- R3: A lookup that matches no valid slot gives `xl_abort`=1 and `xl_hit`=0. `xl_hit`=0 means no DRAM access is started.
- R4: Results are registered. The outputs at the clock edge after a lookup request belong to that request. A cycle with `lk_valid`=0 gives `xl_valid`=`xl_hit`=`xl_abort`=0 at the following edge.
- R5: On each edge while reset is held, `role_master` takes the value of `byte_word` (1 = master, 0 = slave). Changes on `byte_word` after reset do not affect it.
- R6: A write with `prog_sel`=0 is accepted only by a master, and a write with `prog_sel`=1 only by a slave. A write that is not accepted leaves the table unchanged.
- R7: Bit 7 of `xl_ppn` is 1 in a slave and 0 in a master.
- R8: If two or more valid slots hold the looked-up page, the lowest-numbered slot is returned and `xl_multi`=1. A single match gives `xl_multi`=0.
- R9: Writing a new page into a slot replaces its old page. A lookup of the old page then misses, unless another slot holds it.
- R10: A lookup made in the same cycle as a write sees the table as it was before that write.
- R11: An accepted write changes exactly one slot in one clock. Every other slot keeps its mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (asynchronous for the table and outputs; the role is sampled on edges while it is low) |
| byte_word | input | 1 | Role strap, sampled while reset is held |
| prog_we | input | 1 | Table write strobe |
| prog_sel | input | 1 | Write owner select: 0 master, 1 slave |
| prog_idx | input | 7 | Slot (physical page) being written |
| prog_lpn | input | 13 | Logical page stored into the slot |
| lk_valid | input | 1 | Lookup request |
| lk_lpn | input | 13 | Logical page to translate |
| xl_valid | output | 1 | Registered: a lookup result is present |
| xl_hit | output | 1 | Registered: translation found, DRAM access may start |
| xl_abort | output | 1 | Registered: no slot matched |
| xl_multi | output | 1 | Registered: more than one slot matched |
| xl_ppn | output | 8 | Registered physical page {slave bit, slot index} |
| role_master | output | 1 | Latched role, 1 = master |

## Verification
The hardest case to reach is an aliased table, where several valid slots hold one logical page. Writes alone cannot reach it unless software deliberately programs a duplicate. The bench first fills all 128 slots with distinct pages and sweeps every one of them. It then copies a page already held by a middle slot into a higher slot and into a lower slot. This exercises both the lowest-index rule and the replacement of the old page. The slave role can only be entered through reset, so the bench holds reset with the strap low, then repeats the ownership and output-bit checks from that state.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

    typedef enum logic {
        PXC_SLAVE  = 1'b0,
        PXC_MASTER = 1'b1
    } pxc_role_e;

    // Owner select value that each role accepts
    function automatic logic pxc_sel_for(pxc_role_e role);
        return (role == PXC_MASTER) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/pxc_prog_decode.sv
module pxc_prog_decode
    import pxc_pkg::*;
#(
    parameter int N_SLOT = 128,
    localparam int IDX_W = $clog2(N_SLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pxc_role_e         role,
    input  logic              prog_we,
    input  logic              prog_sel,
    input  logic [IDX_W-1:0]  prog_idx,
    output logic              wr_accept,
    output logic [N_SLOT-1:0] wr_vec
);

    always_comb begin
        wr_accept = prog_we && (prog_sel == pxc_sel_for(role));
    end

    for (genvar g = 0; g < N_SLOT; g++) begin : g_sel
        assign wr_vec[g] = wr_accept && (prog_idx == IDX_W'(g));
    end

    // R11: an accepted write selects exactly one slot
    p_one_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> ($countones(wr_vec) == 1));
    p_no_stray_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_accept |-> (wr_vec == '0));

endmodule

// File: rtl/pxc_slot_bank.sv
module pxc_slot_bank #(
    parameter int N_SLOT = 128,
    parameter int LPN_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SLOT-1:0] wr_vec,
    input  logic [LPN_W-1:0]  wr_lpn,
    input  logic [LPN_W-1:0]  lk_lpn,
    output logic [N_SLOT-1:0] match_vec
);

    logic [N_SLOT-1:0] vld_d, vld_q;
    logic [LPN_W-1:0]  lpn_d [N_SLOT];
    logic [LPN_W-1:0]  lpn_q [N_SLOT];

    always_comb begin
        vld_d = vld_q;
        for (int i = 0; i < N_SLOT; i++) begin
            lpn_d[i] = lpn_q[i];
            if (wr_vec[i]) begin
                vld_d[i] = 1'b1;
                lpn_d[i] = wr_lpn;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < N_SLOT; i++) lpn_q[i] <= '0;
        end else begin
            vld_q <= vld_d;
            for (int i = 0; i < N_SLOT; i++) lpn_q[i] <= lpn_d[i];
        end
    end

    // One comparator per slot, all evaluated in parallel
    for (genvar g = 0; g < N_SLOT; g++) begin : g_cmp
        assign match_vec[g] = vld_q[g] && (lpn_q[g] == lk_lpn);
    end

    // R11: slots not addressed by a write keep their valid state
    p_keep_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vec == '0) |=> (vld_q == $past(vld_q)));

endmodule

// File: rtl/pxc_prio_enc.sv
module pxc_prio_enc #(
    parameter int N_SLOT = 128,
    localparam int IDX_W = $clog2(N_SLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SLOT-1:0] match_vec,
    output logic              any,
    output logic              multi,
    output logic [IDX_W-1:0]  idx
);

    always_comb begin
        any   = 1'b0;
        multi = 1'b0;
        idx   = '0;
        for (int i = 0; i < N_SLOT; i++) begin
            if (match_vec[i]) begin
                if (any) begin
                    multi = 1'b1;
                end else begin
                    any = 1'b1;
                    idx = IDX_W'(i);
                end
            end
        end
    end

    // R8: the chosen slot really matched, and a single match never reports aliasing
    p_idx_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> match_vec[idx]);
    p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(match_vec) |-> !multi);

endmodule

// File: rtl/page_xlate_cam.sv
module page_xlate_cam
    import pxc_pkg::*;
#(
    parameter int N_SLOT = 128,
    parameter int LPN_W  = 13,
    localparam int IDX_W = $clog2(N_SLOT),
    localparam int PPN_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_word,
    input  logic             prog_we,
    input  logic             prog_sel,
    input  logic [IDX_W-1:0] prog_idx,
    input  logic [LPN_W-1:0] prog_lpn,
    input  logic             lk_valid,
    input  logic [LPN_W-1:0] lk_lpn,
    output logic             xl_valid,
    output logic             xl_hit,
    output logic             xl_abort,
    output logic             xl_multi,
    output logic [PPN_W-1:0] xl_ppn,
    output logic             role_master
);

    typedef struct packed {
        logic             vld;
        logic             hit;
        logic             abort;
        logic             multi;
        logic [PPN_W-1:0] ppn;
    } xl_res_t;

    pxc_role_e         role_q;
    logic              wr_accept;
    logic [N_SLOT-1:0] wr_vec;
    logic [N_SLOT-1:0] match_vec;
    logic              enc_any, enc_multi;
    logic [IDX_W-1:0]  enc_idx;
    xl_res_t           res_d, res_q;

    // Role strap: follows byte_word while reset is held, frozen afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) role_q <= pxc_role_e'(byte_word);
    end

    pxc_prog_decode #(.N_SLOT(N_SLOT)) i_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .role     (role_q),
        .prog_we  (prog_we),
        .prog_sel (prog_sel),
        .prog_idx (prog_idx),
        .wr_accept(wr_accept),
        .wr_vec   (wr_vec)
    );

    pxc_slot_bank #(.N_SLOT(N_SLOT), .LPN_W(LPN_W)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_vec   (wr_vec),
        .wr_lpn   (prog_lpn),
        .lk_lpn   (lk_lpn),
        .match_vec(match_vec)
    );

    pxc_prio_enc #(.N_SLOT(N_SLOT)) i_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .match_vec(match_vec),
        .any      (enc_any),
        .multi    (enc_multi),
        .idx      (enc_idx)
    );

    always_comb begin
        res_d       = '0;
        res_d.vld   = lk_valid;
        res_d.hit   = lk_valid && enc_any;
        res_d.abort = lk_valid && !enc_any;
        res_d.multi = lk_valid && enc_multi;
        res_d.ppn   = {(role_q == PXC_SLAVE), enc_idx};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign xl_valid    = res_q.vld;
    assign xl_hit      = res_q.hit;
    assign xl_abort    = res_q.abort;
    assign xl_multi    = res_q.multi;
    assign xl_ppn      = res_q.ppn;
    assign role_master = (role_q == PXC_MASTER);

    p_abort_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xl_abort |-> (!xl_hit && xl_valid));
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (xl_valid && (xl_hit != xl_abort)));
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!xl_hit && !xl_abort));
    p_role_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(role_master));
    p_ppn_role_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xl_hit |-> (xl_ppn[PPN_W-1] == !role_master));
    p_multi_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xl_multi |-> xl_hit);

endmodule

// File: tb/test_page_xlate_cam.sv
`timescale 1ns/1ps
module test_page_xlate_cam;

    localparam int N = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_word = 1'b1;
    logic        prog_we = 1'b0, prog_sel = 1'b0;
    logic [6:0]  prog_idx = '0;
    logic [12:0] prog_lpn = '0;
    logic        lk_valid = 1'b0;
    logic [12:0] lk_lpn = '0;
    logic        xl_valid, xl_hit, xl_abort, xl_multi, role_master;
    logic [7:0]  xl_ppn;

    int errors = 0, checks = 0;
    bit done = 0;

    logic [12:0] m_lpn [N];
    bit          m_vld [N];
    bit          m_master;

    page_xlate_cam i_page_xlate_cam (
        .clk(clk), .rst_n(rst_n), .byte_word(byte_word),
        .prog_we(prog_we), .prog_sel(prog_sel), .prog_idx(prog_idx), .prog_lpn(prog_lpn),
        .lk_valid(lk_valid), .lk_lpn(lk_lpn),
        .xl_valid(xl_valid), .xl_hit(xl_hit), .xl_abort(xl_abort), .xl_multi(xl_multi),
        .xl_ppn(xl_ppn), .role_master(role_master)
    );

    always #4 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(bit strap);
        @(negedge clk);
        rst_n = 1'b0; byte_word = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_master = strap;
        for (int i = 0; i < N; i++) m_vld[i] = 0;
    endtask

    task automatic wr(bit sel, int idx, logic [12:0] lpn);
        prog_we = 1'b1; prog_sel = sel; prog_idx = 7'(idx); prog_lpn = lpn;
        @(negedge clk);
        prog_we = 1'b0;
        if (sel == !m_master) begin
            m_vld[idx] = 1; m_lpn[idx] = lpn;
        end
    endtask

    // Drive one lookup, sample one edge later, compare with the model
    task automatic lookup(string req, logic [12:0] lpn);
        int exp_i = -1, cnt = 0;
        for (int i = 0; i < N; i++)
            if (m_vld[i] && m_lpn[i] == lpn) begin
                if (exp_i < 0) exp_i = i;
                cnt++;
            end
        lk_valid = 1'b1; lk_lpn = lpn;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({req, " valid"}, xl_valid, 1);
        chk({req, " hit"}, xl_hit, exp_i >= 0);
        chk({req, " abort"}, xl_abort, exp_i < 0);
        if (exp_i >= 0) begin
            chk({req, " ppn"}, xl_ppn, {!m_master, 7'(exp_i)});
            chk({req, " multi"}, xl_multi, cnt > 1);
        end
    endtask

    function automatic logic [12:0] pat(int i);
        return 13'((i * 97 + 11) & 8191);
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset(1'b1);
        chk("R5 master strap", role_master, 1);
        chk("R4 idle after reset", {xl_valid, xl_hit, xl_abort}, 0);
        // R1: empty table misses everywhere
        for (int k = 0; k < 8; k++) lookup("R1 empty", 13'(k * 1000));

        // R2: fill every slot, sweep every page
        for (int i = 0; i < N; i++) wr(1'b0, i, pat(i));
        for (int i = 0; i < N; i++) lookup("R2 sweep", pat(i));
        // R3: pages not held anywhere
        for (int i = 0; i < 16; i++) lookup("R3 miss", pat(i) + 13'd1);

        // R4: no request -> no result
        @(negedge clk);
        chk("R4 idle", {xl_valid, xl_hit, xl_abort}, 0);

        // R5: strap changes after reset are ignored
        byte_word = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5 hold", role_master, 1);
        lookup("R7 master msb", pat(3));

        // R6: a slave-owned write is ignored by the master
        wr(1'b1, 40, 13'h1ABC);
        lookup("R6 ignored", 13'h1ABC);
        lookup("R6 slot intact", pat(40));

        // R8/R9: alias slot 20's page into slot 100, then into slot 5
        wr(1'b0, 100, pat(20));
        lookup("R8 lowest", pat(20));
        lookup("R9 old page gone", pat(100));
        wr(1'b0, 5, pat(20));
        lookup("R8 lower alias", pat(20));
        lookup("R9 slot5 old gone", pat(5));
        // R11: neighbours of rewritten slots unchanged
        lookup("R11 neighbour", pat(4));
        lookup("R11 neighbour", pat(6));
        lookup("R11 neighbour", pat(101));

        // R10: write and lookup in the same cycle
        prog_we = 1'b1; prog_sel = 1'b0; prog_idx = 7'd9; prog_lpn = 13'h1F0F;
        lk_valid = 1'b1; lk_lpn = 13'h1F0F;
        @(negedge clk);
        prog_we = 1'b0; lk_valid = 1'b0;
        chk("R10 pre-write view abort", xl_abort, 1);
        m_vld[9] = 1; m_lpn[9] = 13'h1F0F;
        lookup("R10 after write", 13'h1F0F);

        // Slave role
        do_reset(1'b0);
        chk("R5 slave strap", role_master, 0);
        lookup("R1 cleared", pat(20));
        wr(1'b0, 7, 13'h0123);
        lookup("R6 master write ignored", 13'h0123);
        for (int i = 0; i < N; i += 9) wr(1'b1, i, pat(i) ^ 13'h0555);
        for (int i = 0; i < N; i += 9) lookup("R7 slave sweep", pat(i) ^ 13'h0555);
        byte_word = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 slave hold", role_master, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule